// File: doc/BRIEF.md
# DMA Request Router Output Channel

This block is one output lane of a DMA request router. A control word picks one of up to 256 peripheral request lines and hands it, one clock later, to a DMA controller channel. In plain mode the chosen line is copied straight through. In gated mode the lane stays closed until an edge of a chosen kind appears on one of the sync lines. It then lets a programmed number of request cycles through and closes again.

Requests are treated as per-cycle strobes. Every cycle in which the chosen request line is high while the lane is open counts as one forwarded request. The lane can emit a one-cycle pulse together with the last request of a batch. A sync edge that arrives while a batch is still open is an overrun: the edge is dropped, and a sticky flag is raised that can drive an interrupt. Software reaches the control word, the flag and its write-one-to-clear register through a simple 32-bit register bus.

Top module: `rtr_chan`

## Requirements
- R1: The control word sits at byte offset 4*(CHAN_IDX-1), which is 0x00 by default. Its fields are: request select in [7:0], overrun interrupt enable in [8], batch-end pulse enable in [9], gated mode in [16], edge kind in [18:17], batch length minus one in [23:19] and sync select in [28:24]. The other bits read as 0.
- R2: With gated mode off, `dma_req_o` equals the selected request input as it was one cycle earlier.
- R3: With gated mode on, nothing is forwarded until a qualifying edge appears on the selected sync input. The edge kind codes are 0 = none qualifies, 1 = rising, 2 = falling and 3 = either.
- R4: After a qualifying edge with no batch open, the next nbreq+1 cycles in which the selected request is high are forwarded, each with one cycle of latency. The lane then closes and waits for a new edge.
- R5: When bit 9 is set, `evt_o` is high for exactly the cycle in which the last request of a batch appears on `dma_req_o`. When bit 9 is clear, `evt_o` never pulses.
- R6: A qualifying edge that arrives while a batch is open sets the overrun flag. The flag reads at offset 0x80, bit CHAN_IDX-1. Such an edge does not restart or extend the batch.
- R7: Writing 1 to bit CHAN_IDX-1 at offset 0x84 clears the flag, and writing 0 there leaves it unchanged. If an overrun occurs in the same cycle as the clear, the flag stays set.
- R8: `irq_o` is high exactly when the overrun flag and the enable in bit 8 are both set.
- R9: After reset the control word and the flag are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| req_in | input | NUM_REQ | Peripheral request lines |
| sync_in | input | NUM_SYNC | Sync event lines |
| dma_req_o | output | 1 | Request to the DMA controller channel |
| evt_o | output | 1 | Batch-end pulse |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The bench first holds the request line high before any sync edge and checks that a gated lane leaks nothing. A design that opened at reset, or on an edge of the wrong kind, would forward requests early. It then counts forwarded requests for batch lengths of 1 and 3 under each edge kind. An off-by-one counter would let one request too many or too few through. Finally it fires a second edge while a batch is held open and checks that the flag rises and the batch length stays unchanged. A design that reloaded on that edge would forward extra requests, and one with a clear that ignores the written bit would lose the flag.

// File: rtl/rtr_pkg.sv
// Shared field layout and edge codes for the request router lane.
// Assumes a 32-bit register bus and the bit positions given in the brief.
package rtr_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_kind_t;

    typedef struct packed {
        logic [4:0] sync_sel;
        logic [4:0] burst_m1;
        edge_kind_t edge_kind;
        logic       gate_en;
        logic       pulse_en;
        logic       ovr_irq_en;
        logic [7:0] req_sel;
    } lane_cfg_t;

    localparam int F_REQ_LO   = 0;
    localparam int F_IRQ_EN   = 8;
    localparam int F_PULSE_EN = 9;
    localparam int F_GATE_EN  = 16;
    localparam int F_EDGE_LO  = 17;
    localparam int F_BURST_LO = 19;
    localparam int F_SYNC_LO  = 24;
endpackage

// File: rtl/rtr_cfg_regs.sv
// Register file of one lane: control word, sticky overrun flag and its
// write-one-to-clear port. Assumes single-cycle writes and combinational reads.
module rtr_cfg_regs
    import rtr_pkg::*;
#(
    parameter int CHAN_IDX = 1,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ovr_set,
    output lane_cfg_t         cfg_o,
    output logic              flag_o
);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4 * (CHAN_IDX - 1));
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(12'h080);
    localparam logic [ADDR_W-1:0] CLR_OFS  = ADDR_W'(12'h084);
    localparam int               FLAG_BIT = CHAN_IDX - 1;

    logic wr_ctrl, wr_clr, clr_hit;
    logic [31:0] ctrl_word;

    assign wr_ctrl = bus_sel && bus_we && (bus_addr == CTRL_OFS);
    assign wr_clr  = bus_sel && bus_we && (bus_addr == CLR_OFS);
    assign clr_hit = wr_clr && bus_wdata[FLAG_BIT];

    // Capture the control word on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (wr_ctrl) begin
            cfg_o.req_sel    <= bus_wdata[F_REQ_LO +: 8];
            cfg_o.ovr_irq_en <= bus_wdata[F_IRQ_EN];
            cfg_o.pulse_en   <= bus_wdata[F_PULSE_EN];
            cfg_o.gate_en    <= bus_wdata[F_GATE_EN];
            cfg_o.edge_kind  <= edge_kind_t'(bus_wdata[F_EDGE_LO +: 2]);
            cfg_o.burst_m1   <= bus_wdata[F_BURST_LO +: 5];
            cfg_o.sync_sel   <= bus_wdata[F_SYNC_LO +: 5];
        end
    end

    // Sticky overrun flag; a new overrun beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= ovr_set || (flag_o && !clr_hit);
    end

    // Rebuild the control word image for reads.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[F_REQ_LO +: 8]   = cfg_o.req_sel;
        ctrl_word[F_IRQ_EN]        = cfg_o.ovr_irq_en;
        ctrl_word[F_PULSE_EN]      = cfg_o.pulse_en;
        ctrl_word[F_GATE_EN]       = cfg_o.gate_en;
        ctrl_word[F_EDGE_LO +: 2]  = cfg_o.edge_kind;
        ctrl_word[F_BURST_LO +: 5] = cfg_o.burst_m1;
        ctrl_word[F_SYNC_LO +: 5]  = cfg_o.sync_sel;
    end

    // Read multiplexer by address.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS)      bus_rdata = ctrl_word;
        else if (bus_addr == STAT_OFS) bus_rdata[FLAG_BIT] = flag_o;
    end

    p_ovr_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> flag_o);
    p_clear_drops_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !ovr_set) |=> !flag_o);
endmodule

// File: rtl/rtr_sync_edge.sv
// Picks one sync line and reports a qualifying edge of the programmed kind.
// Assumes the sync lines are already in the lane's clock domain.
module rtr_sync_edge
    import rtr_pkg::*;
#(
    parameter int NUM_SYNC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SYNC-1:0] sync_in,
    input  logic [4:0]          sync_sel,
    input  edge_kind_t          edge_kind,
    output logic                hit_o
);
    logic [NUM_SYNC-1:0] sync_q;
    logic cur, old;

    // Keep last cycle's sample of every sync line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_in;
    end

    // Select the line; an out-of-range select sees a constant low.
    always_comb begin
        cur = 1'b0;
        old = 1'b0;
        if (32'(sync_sel) < NUM_SYNC) begin
            cur = sync_in[sync_sel];
            old = sync_q[sync_sel];
        end
    end

    // Qualify the edge by its kind.
    always_comb begin
        unique case (edge_kind)
            EDGE_RISE: hit_o = cur && !old;
            EDGE_FALL: hit_o = !cur && old;
            EDGE_ANY:  hit_o = cur != old;
            default:   hit_o = 1'b0;
        endcase
    end

    p_no_hit_when_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_kind == EDGE_NONE) |-> !hit_o);
endmodule

// File: rtl/rtr_burst_gate.sv
// Selects one request line and forwards it, either freely or in counted
// batches opened by a sync hit. Flags hits that land inside an open batch.
// Assumes each high cycle of the selected line is one request.
module rtr_burst_gate
    import rtr_pkg::*;
#(
    parameter int NUM_REQ = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_in,
    input  lane_cfg_t          cfg,
    input  logic               sync_hit,
    output logic               dma_req_o,
    output logic               evt_o,
    output logic               ovr_o
);
    localparam int CNT_W = 6;

    logic [CNT_W-1:0] left;
    logic sel_req, open, fwd, last;

    // Pick the request line; an out-of-range select sees a constant low.
    always_comb begin
        sel_req = 1'b0;
        if (32'(cfg.req_sel) < NUM_REQ) sel_req = req_in[cfg.req_sel];
    end

    assign open  = left != '0;
    assign fwd   = sel_req && open;
    assign last  = fwd && (left == CNT_W'(1));
    assign ovr_o = cfg.gate_en && sync_hit && open;

    // Output register and batch counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left      <= '0;
            dma_req_o <= 1'b0;
            evt_o     <= 1'b0;
        end else if (!cfg.gate_en) begin
            left      <= '0;
            dma_req_o <= sel_req;
            evt_o     <= 1'b0;
        end else begin
            dma_req_o <= fwd;
            evt_o     <= last && cfg.pulse_en;
            if (sync_hit && !open) left <= CNT_W'(cfg.burst_m1) + CNT_W'(1);
            else if (fwd)          left <= left - CNT_W'(1);
        end
    end

    p_closed_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gate_en && !open) |=> !dma_req_o);
    p_load_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gate_en && sync_hit && !open) |=> (left == CNT_W'($past(cfg.burst_m1)) + CNT_W'(1)));
    p_pulse_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> dma_req_o);
endmodule

// File: rtl/rtr_chan.sv
// One output lane of a DMA request router: register file, sync edge
// qualifier and batch gate. Assumes one clock and a synchronous active-low reset.
module rtr_chan
    import rtr_pkg::*;
#(
    parameter int CHAN_IDX = 1,
    parameter int ADDR_W   = 12,
    parameter int NUM_REQ  = 256,
    parameter int NUM_SYNC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_REQ-1:0]  req_in,
    input  logic [NUM_SYNC-1:0] sync_in,
    output logic                dma_req_o,
    output logic                evt_o,
    output logic                irq_o
);
    lane_cfg_t cfg;
    logic flag, hit, ovr;

    rtr_cfg_regs #(.CHAN_IDX(CHAN_IDX), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovr_set(ovr), .cfg_o(cfg), .flag_o(flag));

    rtr_sync_edge #(.NUM_SYNC(NUM_SYNC)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_sel(cfg.sync_sel),
        .edge_kind(cfg.edge_kind), .hit_o(hit));

    rtr_burst_gate #(.NUM_REQ(NUM_REQ)) u_gate (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg(cfg), .sync_hit(hit),
        .dma_req_o(dma_req_o), .evt_o(evt_o), .ovr_o(ovr));

    // Interrupt needs both the flag and its enable.
    assign irq_o = flag && cfg.ovr_irq_en;

    p_irq_follows_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && cfg.ovr_irq_en && !(bus_sel && bus_we)) |=> irq_o);
endmodule

// File: tb/rtr_chan_tb.sv
module rtr_chan_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [255:0] req_in = '0;
    logic [31:0] sync_in = '0;
    logic dma_req_o, evt_o, irq_o;

    int tests = 0, fails = 0;
    int nreq = 0, nevt = 0;

    always #5 clk = ~clk;

    rtr_chan u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_in(req_in), .sync_in(sync_in), .dma_req_o(dma_req_o),
        .evt_o(evt_o), .irq_o(irq_o));

    // Behavioural reference model
    int m_req_sel, m_sync_sel, m_burst, m_edge;
    bit m_gate, m_pulse, m_irq_en, m_flag, m_out, m_evt;
    int m_left;
    logic [31:0] m_prev;

    always @(posedge clk) begin
        bit s, cur, pv, q, f, ovr, clr;
        if (!rst_n) begin
            m_req_sel = 0; m_sync_sel = 0; m_burst = 0; m_edge = 0;
            m_gate = 0; m_pulse = 0; m_irq_en = 0; m_flag = 0;
            m_out = 0; m_evt = 0; m_left = 0; m_prev = '0;
        end else begin
            s = req_in[m_req_sel];
            cur = sync_in[m_sync_sel];
            pv = m_prev[m_sync_sel];
            case (m_edge)
                1: q = cur && !pv;
                2: q = !cur && pv;
                3: q = cur != pv;
                default: q = 0;
            endcase
            ovr = 0;
            if (m_gate) begin
                f = s && (m_left > 0);
                m_out = f;
                m_evt = f && (m_left == 1) && m_pulse;
                if (q && m_left == 0) m_left = m_burst + 1;
                else begin
                    if (q) ovr = 1;
                    if (f) m_left = m_left - 1;
                end
            end else begin
                m_out = s; m_evt = 0; m_left = 0;
            end
            clr = bus_sel && bus_we && bus_addr == 12'h084 && bus_wdata[0];
            m_flag = ovr || (m_flag && !clr);
            if (bus_sel && bus_we && bus_addr == 12'h000) begin
                m_req_sel = bus_wdata[7:0];
                m_irq_en = bus_wdata[8];
                m_pulse = bus_wdata[9];
                m_gate = bus_wdata[16];
                m_edge = bus_wdata[18:17];
                m_burst = bus_wdata[23:19];
                m_sync_sel = bus_wdata[28:24];
            end
            m_prev = sync_in;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, plus request and pulse counting.
    always @(negedge clk) begin
        check(dma_req_o == m_out, "R2 R4 dma_req_o", dma_req_o, m_out);
        check(evt_o == m_evt, "R5 evt_o", evt_o, m_evt);
        check(irq_o == (m_flag && m_irq_en), "R8 irq_o", irq_o, m_flag && m_irq_en);
        if (rst_n) begin
            if (dma_req_o) nreq++;
            if (evt_o) nevt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_cnt();
        @(negedge clk);
        #2;
        nreq = 0;
        nevt = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 0;
    endtask

    function automatic logic [31:0] cw(int req, int irq, int pulse, int gate,
                                       int edk, int burst_m1, int sync);
        return 32'(req) | 32'(irq << 8) | 32'(pulse << 9) | 32'(gate << 16) |
               32'(edk << 17) | 32'(burst_m1 << 19) | 32'(sync << 24);
    endfunction

    initial begin
        tick(5);
        rst_n = 1;
        // R9: reset state
        rd(12'h000, 32'h0, "R9 ctrl after reset");
        rd(12'h080, 32'h0, "R9 flag after reset");
        check(!dma_req_o && !evt_o && !irq_o, "R9 outputs after reset", 0, 0);

        // R1: field positions and read-back masking
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, 32'h1FFF_03FF, "R1 ctrl readback");

        // R2: plain pass-through of line 5
        wr(12'h000, cw(5, 0, 0, 0, 0, 0, 0));
        clr_cnt();
        req_in[5] = 1; tick(4); req_in[5] = 0; tick(3);
        check(nreq == 4, "R2 pass-through count", nreq, 4);
        wr(12'h000, cw(200, 0, 0, 0, 0, 0, 0));
        clr_cnt();
        req_in[200] = 1; tick(2); req_in[200] = 0; tick(3);
        check(nreq == 2, "R2 high line select", nreq, 2);

        // R3/R4/R5: rising edge, batch of 3, pulse on
        req_in[5] = 1;
        wr(12'h000, cw(5, 0, 1, 1, 1, 2, 3));
        clr_cnt(); tick(10);
        check(nreq == 0, "R3 closed before edge", nreq, 0);
        sync_in[3] = 1; tick(12);
        check(nreq == 3, "R4 batch of three", nreq, 3);
        check(nevt == 1, "R5 one batch-end pulse", nevt, 1);
        sync_in[3] = 0; tick(6);
        check(nreq == 3, "R3 falling ignored in rise mode", nreq, 3);

        // R3: falling kind
        wr(12'h000, cw(5, 0, 1, 1, 2, 2, 3));
        clr_cnt();
        sync_in[3] = 1; tick(4);
        check(nreq == 0, "R3 rise ignored in fall mode", nreq, 0);
        sync_in[3] = 0; tick(10);
        check(nreq == 3, "R3 fall opens batch", nreq, 3);

        // R3/R5: either edge, batch of 1, pulse off
        wr(12'h000, cw(5, 0, 0, 1, 3, 0, 3));
        clr_cnt();
        sync_in[3] = 1; tick(6); sync_in[3] = 0; tick(6);
        check(nreq == 2, "R3 both edges count", nreq, 2);
        check(nevt == 0, "R5 no pulse when disabled", nevt, 0);

        // R3: no edge kind
        wr(12'h000, cw(5, 0, 1, 1, 0, 0, 3));
        clr_cnt();
        sync_in[3] = 1; tick(4); sync_in[3] = 0; tick(4);
        check(nreq == 0, "R3 kind none never opens", nreq, 0);

        // R6/R8: overrun while batch held open
        req_in[5] = 0;
        wr(12'h000, cw(5, 1, 1, 1, 1, 3, 3));
        tick(2);
        sync_in[3] = 1; tick(2); sync_in[3] = 0; tick(2);
        sync_in[3] = 1; tick(2);
        check(irq_o == 1, "R8 irq on overrun", irq_o, 1);
        rd(12'h080, 32'h1, "R6 flag set");
        clr_cnt();
        req_in[5] = 1; tick(10); req_in[5] = 0;
        check(nreq == 4, "R6 overrun did not extend batch", nreq, 4);

        // R7: clear semantics
        wr(12'h084, 32'h0);
        rd(12'h080, 32'h1, "R7 write zero keeps flag");
        wr(12'h084, 32'h1);
        rd(12'h080, 32'h0, "R7 write one clears flag");
        check(irq_o == 0, "R8 irq low after clear", irq_o, 0);

        // R8: flag set but interrupt disabled
        sync_in[3] = 0; tick(2);
        sync_in[3] = 1; tick(2); sync_in[3] = 0; tick(2);
        sync_in[3] = 1; tick(2);
        wr(12'h000, cw(5, 0, 1, 1, 1, 3, 3));
        rd(12'h080, 32'h1, "R6 flag set again");
        check(irq_o == 0, "R8 irq masked", irq_o, 0);

        tick(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule